// File: doc/BRIEF.md
# Ping-pong IN endpoint transmit buffer

This block is the device-side transmit store for one bulk or interrupt IN endpoint. It has two equal banks that take turns. Firmware fills the bank under its write pointer one byte at a time and then arms it. Arming hands that bank to the transmit side and moves the write pointer to the other bank in the same step, so firmware can prepare the next packet while the previous one waits for the host.

On the bus side, a simplified packet engine signals an IN token, a host ACK, or a missing handshake (timeout). For each token the block does one of three things:
- It streams the oldest armed bank: a start strobe carrying the data PID, then the bytes one per cycle, then an end strobe.
- It answers NAK if that bank is not armed.
- It stays silent if the endpoint is disabled.

Retries, bank order and the data toggle are all handled inside the block. An acknowledged packet sets a completion flag that firmware clears by writing one. An optional interrupt follows that flag.

Top module: `usbin_pingpong`

## Requirements
- R1: While `ep_en` is low, byte writes and `set_rdy` have no effect, and an IN token produces neither `tx_sop`, `tx_valid` nor `tx_nak`.
- R2: `set_rdy` arms the bank under the write pointer and toggles `wr_bank` (0 = bank 0, 1 = bank 1) in the next cycle. A token on an armed bank gives `tx_sop` in the cycle after the token, then one `tx_valid` byte per cycle in write order, then one `tx_eop` cycle.
- R3: A token aimed at a bank that is not armed gives a one-cycle `tx_nak` in the cycle after the token and no `tx_sop` or `tx_valid`.
- R4: A host ACK while the block waits after `tx_eop` sets `txcmpl` in the next cycle. `irq` equals `txcmpl` AND `irq_en`.
- R5: A byte write or `set_rdy` aimed at a bank that is still armed, or whose ACK has arrived but whose completion is not yet cleared, is ignored and sets the sticky `overrun`. `clr_ovr` clears `overrun`.
- R6: Banks are transmitted strictly alternately, starting at bank 0 after reset or re-enable.
- R7: `tx_pid` during `tx_sop` is 0 for DATA0 and 1 for DATA1. It starts at DATA0 and flips after each acknowledged packet.
- R8: A `host_tmo` while waiting for the handshake leaves `txcmpl` low. The next token resends the same bank with the same PID.
- R9: A bank holds up to DEPTH bytes. Further writes are ignored and set `overrun`. An armed empty bank sends `tx_sop` followed directly by `tx_eop`.
- R10: Reset, or `ep_en` low for one cycle, disarms both banks, clears `txcmpl`, returns `wr_bank` to 0 and the PID to DATA0.
- R11: `clr_cmpl` clears the completion pending at that moment. An ACK that arrives in the same cycle as `clr_cmpl` leaves `txcmpl` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ep_en | input | 1 | Endpoint enable |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Byte write strobe into the fill bank |
| wr_data | input | DATA_W | Byte to write |
| set_rdy | input | 1 | Arm the fill bank (pulse) |
| clr_cmpl | input | 1 | Write-one-to-clear of the completion flag |
| clr_ovr | input | 1 | Clear the overrun flag |
| in_tok | input | 1 | IN token for this endpoint (pulse) |
| host_ack | input | 1 | Host ACK received (pulse) |
| host_tmo | input | 1 | Handshake timeout (pulse) |
| txcmpl | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |
| overrun | output | 1 | Sticky ignored-access flag |
| wr_bank | output | 1 | Bank under the CPU write pointer |
| tx_sop | output | 1 | Packet start, PID valid |
| tx_pid | output | 1 | Data PID, 0 = DATA0, 1 = DATA1 |
| tx_valid | output | 1 | Payload byte valid |
| tx_data | output | DATA_W | Payload byte |
| tx_eop | output | 1 | Packet end |
| tx_nak | output | 1 | NAK handshake request |

## Verification
The two events that can meet in one cycle are a host ACK, which raises a completion, and a firmware clear of an earlier completion. The bench first leaves the completion for bank 0 uncleared. It then sends bank 1 and drives `host_ack` and `clr_cmpl` on the same edge. It requires `txcmpl` to remain high afterwards, and to fall only after a second clear. A similar overlap is a byte write during the cycles when the other bank is in flight or awaiting its clear. For that case the bench compares the later packet contents byte by byte against values it computes from seed and index.

// File: rtl/usbin_pkg.sv
package usbin_pkg;
   typedef enum logic [2:0] {
      TX_IDLE = 3'd0,
      TX_SOP  = 3'd1,
      TX_DATA = 3'd2,
      TX_EOP  = 3'd3,
      TX_WAIT = 3'd4
   } tx_state_t;

   typedef enum logic {
      PID_DATA0 = 1'b0,
      PID_DATA1 = 1'b1
   } pid_t;

   localparam int NUM_BANKS = 2;
endpackage

// File: rtl/usbin_bank_ram.sv
module usbin_bank_ram #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/usbin_fill_ctl.sv
module usbin_fill_ctl #(
   parameter int DEPTH = 64,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ep_en,
   input  logic              wr_en,
   input  logic              set_rdy,
   input  logic              clr_cmpl,
   input  logic              clr_ovr,
   input  logic              ack_evt,
   input  logic              ack_bank,
   output logic [1:0]        armed,
   output logic [1:0]        done,
   output logic [CNT_W-1:0]  cnt [2],
   output logic              wr_ptr,
   output logic              overrun,
   output logic [1:0]        ram_we,
   output logic [ADDR_W-1:0] ram_waddr
);
   logic [1:0]       writable;
   logic [1:0]       wsel;
   logic [1:0]       asel;
   logic [CNT_W-1:0] cur_cnt;
   logic             cur_ok;
   logic             cur_full;
   logic             wr_ok;
   logic             wr_bad;
   logic             arm_ok;
   logic             arm_bad;

   always_comb begin
      for (int b = 0; b < 2; b++) writable[b] = !armed[b] && !done[b];
      wsel      = wr_ptr ? 2'b10 : 2'b01;
      asel      = ack_evt ? (ack_bank ? 2'b10 : 2'b01) : 2'b00;
      cur_cnt   = cnt[wr_ptr];
      cur_ok    = writable[wr_ptr];
      cur_full  = (cur_cnt == CNT_W'(DEPTH));
      wr_ok     = ep_en && wr_en && cur_ok && !cur_full;
      wr_bad    = ep_en && wr_en && !(cur_ok && !cur_full);
      arm_ok    = ep_en && set_rdy && cur_ok;
      arm_bad   = ep_en && set_rdy && !cur_ok;
      ram_we    = wr_ok ? wsel : 2'b00;
      ram_waddr = cur_cnt[ADDR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= '0;
         done    <= '0;
         wr_ptr  <= 1'b0;
         overrun <= 1'b0;
         for (int b = 0; b < 2; b++) cnt[b] <= '0;
      end else begin
         overrun <= (overrun && !clr_ovr) || wr_bad || arm_bad;
         if (!ep_en) begin
            armed  <= '0;
            done   <= '0;
            wr_ptr <= 1'b0;
            for (int b = 0; b < 2; b++) cnt[b] <= '0;
         end else begin
            if (arm_ok) wr_ptr <= !wr_ptr;
            for (int b = 0; b < 2; b++) begin
               armed[b] <= (armed[b] && !asel[b]) || (arm_ok && wsel[b]);
               done[b]  <= (done[b] && !clr_cmpl) || asel[b];
               if (asel[b])        cnt[b] <= '0;
               else if (ram_we[b]) cnt[b] <= cnt[b] + CNT_W'(1);
            end
         end
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_chk
      AST_ARM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(armed[g]) |-> $past(ep_en)); // R1
      AST_CNT_FROZEN_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
         (armed[g] && $past(armed[g])) |-> $stable(cnt[g])); // R5
      AST_DONE_FROM_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(done[g]) |-> ($past(ack_evt) && ($past(ack_bank) == 1'(g)))); // R4
   end
endmodule

// File: rtl/usbin_tx_fsm.sv
module usbin_tx_fsm
   import usbin_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ep_en,
   input  logic              in_tok,
   input  logic              host_ack,
   input  logic              host_tmo,
   input  logic              armed_cur,
   input  logic [CNT_W-1:0]  cnt_cur,
   output logic              tx_ptr,
   output logic              pid_bit,
   output logic [ADDR_W-1:0] rd_idx,
   output logic              ack_evt,
   output logic              tx_sop,
   output logic              tx_valid,
   output logic              tx_eop,
   output logic              tx_nak
);
   tx_state_t         state;
   pid_t              toggle;
   logic [ADDR_W-1:0] idx;
   logic              nak_q;
   logic              last_byte;

   assign last_byte = ((CNT_W'(idx) + CNT_W'(1)) == cnt_cur);
   assign ack_evt   = ep_en && (state == TX_WAIT) && host_ack;
   assign tx_sop    = (state == TX_SOP);
   assign tx_valid  = (state == TX_DATA);
   assign tx_eop    = (state == TX_EOP);
   assign tx_nak    = nak_q;
   assign pid_bit   = toggle;
   assign rd_idx    = idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= TX_IDLE;
         toggle <= PID_DATA0;
         tx_ptr <= 1'b0;
         idx    <= '0;
         nak_q  <= 1'b0;
      end else if (!ep_en) begin
         state  <= TX_IDLE;
         toggle <= PID_DATA0;
         tx_ptr <= 1'b0;
         idx    <= '0;
         nak_q  <= 1'b0;
      end else begin
         nak_q <= 1'b0;
         case (state)
            TX_IDLE: begin
               if (in_tok) begin
                  if (armed_cur) state <= TX_SOP;
                  else           nak_q <= 1'b1;
               end
            end
            TX_SOP: begin
               idx   <= '0;
               state <= (cnt_cur == '0) ? TX_EOP : TX_DATA;
            end
            TX_DATA: begin
               if (last_byte) state <= TX_EOP;
               else           idx   <= idx + ADDR_W'(1);
            end
            TX_EOP: state <= TX_WAIT;
            TX_WAIT: begin
               if (host_ack) begin
                  state  <= TX_IDLE;
                  toggle <= (toggle == PID_DATA0) ? PID_DATA1 : PID_DATA0;
                  tx_ptr <= !tx_ptr;
               end else if (host_tmo) begin
                  state <= TX_IDLE;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_sop, tx_valid, tx_eop, tx_nak})); // R3
   AST_SOP_ONLY_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sop |-> armed_cur); // R3
   AST_RETRY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ep_en && state == TX_WAIT && host_tmo && !host_ack)
      |=> (tx_ptr == $past(tx_ptr) && toggle == $past(toggle))); // R8
   AST_ACK_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      ack_evt |=> (tx_ptr != $past(tx_ptr) && toggle != $past(toggle))); // R6
endmodule

// File: rtl/usbin_pingpong.sv
module usbin_pingpong
   import usbin_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ep_en,
   input  logic              irq_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              set_rdy,
   input  logic              clr_cmpl,
   input  logic              clr_ovr,
   input  logic              in_tok,
   input  logic              host_ack,
   input  logic              host_tmo,
   output logic              txcmpl,
   output logic              irq,
   output logic              overrun,
   output logic              wr_bank,
   output logic              tx_sop,
   output logic              tx_pid,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   output logic              tx_eop,
   output logic              tx_nak
);
   localparam int ADDR_W = $clog2(DEPTH);
   localparam int CNT_W  = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("usbin_pingpong: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("usbin_pingpong: DATA_W must be at least 1");
   end

   logic [1:0]        armed;
   logic [1:0]        done;
   logic [CNT_W-1:0]  cnt [2];
   logic [1:0]        ram_we;
   logic [ADDR_W-1:0] ram_waddr;
   logic [ADDR_W-1:0] rd_idx;
   logic [DATA_W-1:0] rdata [NUM_BANKS];
   logic              tx_ptr;
   logic              ack_evt;

   usbin_fill_ctl #(.DEPTH(DEPTH)) u_fill (
      .clk      (clk),
      .rst_n    (rst_n),
      .ep_en    (ep_en),
      .wr_en    (wr_en),
      .set_rdy  (set_rdy),
      .clr_cmpl (clr_cmpl),
      .clr_ovr  (clr_ovr),
      .ack_evt  (ack_evt),
      .ack_bank (tx_ptr),
      .armed    (armed),
      .done     (done),
      .cnt      (cnt),
      .wr_ptr   (wr_bank),
      .overrun  (overrun),
      .ram_we   (ram_we),
      .ram_waddr(ram_waddr)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      usbin_bank_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ram (
         .clk  (clk),
         .we   (ram_we[g]),
         .waddr(ram_waddr),
         .wdata(wr_data),
         .raddr(rd_idx),
         .rdata(rdata[g])
      );
   end

   usbin_tx_fsm #(.DEPTH(DEPTH)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ep_en    (ep_en),
      .in_tok   (in_tok),
      .host_ack (host_ack),
      .host_tmo (host_tmo),
      .armed_cur(armed[tx_ptr]),
      .cnt_cur  (cnt[tx_ptr]),
      .tx_ptr   (tx_ptr),
      .pid_bit  (tx_pid),
      .rd_idx   (rd_idx),
      .ack_evt  (ack_evt),
      .tx_sop   (tx_sop),
      .tx_valid (tx_valid),
      .tx_eop   (tx_eop),
      .tx_nak   (tx_nak)
   );

   assign tx_data = rdata[tx_ptr];
   assign txcmpl  = |done;
   assign irq     = txcmpl && irq_en;

   AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ep_en) |-> (!txcmpl && !wr_bank && !tx_sop && !tx_nak)); // R10
   AST_ACK_RAISES_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
      ack_evt |=> txcmpl); // R11
endmodule

// File: tb/usbin_pingpong_test.sv
`timescale 1ns/1ps
module usbin_pingpong_test;
   localparam int D  = 4;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n, ep_en, irq_en, wr_en, set_rdy, clr_cmpl, clr_ovr;
   logic in_tok, host_ack, host_tmo;
   logic [DW-1:0] wr_data;
   logic txcmpl, irq, overrun, wr_bank, tx_sop, tx_pid, tx_valid, tx_eop, tx_nak;
   logic [DW-1:0] tx_data;

   int total = 0;
   int fails = 0;

   always #5 clk = ~clk;

   usbin_pingpong #(.DATA_W(DW), .DEPTH(D)) uut (
      .clk(clk), .rst_n(rst_n), .ep_en(ep_en), .irq_en(irq_en),
      .wr_en(wr_en), .wr_data(wr_data), .set_rdy(set_rdy),
      .clr_cmpl(clr_cmpl), .clr_ovr(clr_ovr), .in_tok(in_tok),
      .host_ack(host_ack), .host_tmo(host_tmo), .txcmpl(txcmpl),
      .irq(irq), .overrun(overrun), .wr_bank(wr_bank), .tx_sop(tx_sop),
      .tx_pid(tx_pid), .tx_valid(tx_valid), .tx_data(tx_data),
      .tx_eop(tx_eop), .tx_nak(tx_nak)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int pat(input int seed, input int i);
      return (seed * 37 + i * 11 + 5) & 255;
   endfunction

   task automatic fill(input int len, input int seed);
      for (int i = 0; i < len; i++) begin
         wr_en = 1'b1; wr_data = DW'(pat(seed, i));
         @(negedge clk);
      end
      wr_en = 1'b0;
   endtask

   task automatic arm();
      set_rdy = 1'b1; @(negedge clk); set_rdy = 1'b0;
   endtask

   task automatic ack();
      host_ack = 1'b1; @(negedge clk); host_ack = 1'b0;
   endtask

   task automatic clr();
      clr_cmpl = 1'b1; @(negedge clk); clr_cmpl = 1'b0;
   endtask

   task automatic restart();
      ep_en = 1'b0; @(negedge clk); ep_en = 1'b1; @(negedge clk);
   endtask

   // token, then expect sop+pid, exp_len bytes in order, eop; leaves block waiting
   task automatic get_pkt(input int exp_len, input int seed, input int exp_pid, input string tag);
      int n = 0;
      bit seen_eop = 0;
      in_tok = 1'b1; @(negedge clk); in_tok = 1'b0;
      chk({tag, " sop"}, int'(tx_sop), 1);
      chk({tag, " pid"}, int'(tx_pid), exp_pid);
      for (int c = 0; c < D + 2 && !seen_eop; c++) begin
         @(negedge clk);
         if (tx_valid) begin
            chk({tag, " byte"}, int'(tx_data), pat(seed, n));
            n++;
         end
         if (tx_eop) seen_eop = 1;
      end
      chk({tag, " eop"}, int'(seen_eop), 1);
      chk({tag, " length"}, n, exp_len);
      @(negedge clk);
   endtask

   initial begin
      #2000000;
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      rst_n = 1'b0; ep_en = 1'b0; irq_en = 1'b0; wr_en = 1'b0; wr_data = '0;
      set_rdy = 1'b0; clr_cmpl = 1'b0; clr_ovr = 1'b0;
      in_tok = 1'b0; host_ack = 1'b0; host_tmo = 1'b0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset txcmpl", int'(txcmpl), 0);
      chk("R10 reset overrun", int'(overrun), 0);
      chk("R10 reset wr_bank", int'(wr_bank), 0);
      chk("R10 reset strobes", int'({tx_sop, tx_valid, tx_eop, tx_nak}), 0);
      rst_n = 1'b1; @(negedge clk);

      // R1 disabled: writes, arm and token do nothing
      fill(2, 1); arm();
      chk("R1 wr_bank disabled", int'(wr_bank), 0);
      chk("R1 overrun disabled", int'(overrun), 0);
      in_tok = 1'b1; @(negedge clk); in_tok = 1'b0;
      for (int c = 0; c < 3; c++) begin
         chk("R1 silent token", int'({tx_sop, tx_valid, tx_nak}), 0);
         @(negedge clk);
      end
      ep_en = 1'b1; @(negedge clk);
      in_tok = 1'b1; @(negedge clk); in_tok = 1'b0;
      chk("R1 nothing armed while off", int'(tx_nak), 1);
      @(negedge clk);

      // R2 R6 R7 R9 sweep over lengths 0..D, banks filled ahead of sending
      irq_en = 1'b1;
      for (int k = 0; k < 5; k++) begin
         int la = (2 * k) % (D + 1);
         int lb = (2 * k + 1) % (D + 1);
         fill(la, 10 + 2 * k); arm();
         chk("R2 wr_bank after first arm", int'(wr_bank), 1);
         fill(lb, 11 + 2 * k); arm();
         chk("R2 wr_bank after second arm", int'(wr_bank), 0);
         get_pkt(la, 10 + 2 * k, 0, "R6 R7 R9 bank0");
         ack();
         chk("R4 txcmpl after ack", int'(txcmpl), 1);
         chk("R4 irq enabled", int'(irq), 1);
         clr();
         chk("R11 plain clear", int'(txcmpl), 0);
         get_pkt(lb, 11 + 2 * k, 1, "R6 R7 R9 bank1");
         ack(); clr();
      end
      irq_en = 1'b0;

      // R3 NAK on filled but unarmed bank
      restart();
      fill(2, 90);
      in_tok = 1'b1; @(negedge clk); in_tok = 1'b0;
      chk("R3 nak", int'(tx_nak), 1);
      chk("R3 no sop", int'(tx_sop), 0);
      @(negedge clk);
      chk("R3 nak single cycle", int'(tx_nak), 0);
      chk("R3 no data", int'(tx_valid), 0);

      // R8 retry
      restart();
      fill(3, 80); arm();
      get_pkt(3, 80, 0, "R8 first try");
      host_tmo = 1'b1; @(negedge clk); host_tmo = 1'b0;
      chk("R8 no completion on timeout", int'(txcmpl), 0);
      get_pkt(3, 80, 0, "R8 resend");
      ack();
      chk("R8 completion after ack", int'(txcmpl), 1);
      chk("R4 irq disabled", int'(irq), 0);
      clr();

      // R5 overrun on armed bank and on acked-but-uncleared bank
      restart();
      fill(2, 50); arm(); fill(1, 51); arm();
      fill(1, 99);
      chk("R5 overrun write armed", int'(overrun), 1);
      arm();
      chk("R5 arm ignored", int'(wr_bank), 0);
      clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
      chk("R5 clr_ovr", int'(overrun), 0);
      get_pkt(2, 50, 0, "R5 bank0 unchanged");
      ack();
      fill(1, 98);
      chk("R5 overrun before clear", int'(overrun), 1);
      clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;
      clr();
      fill(3, 52);
      chk("R5 refill after clear", int'(overrun), 0);
      arm();
      get_pkt(1, 51, 1, "R5 bank1"); ack(); clr();
      get_pkt(3, 52, 0, "R5 bank0 refilled"); ack(); clr();

      // R9 capacity
      restart();
      fill(D + 1, 60);
      chk("R9 overrun past depth", int'(overrun), 1);
      arm();
      get_pkt(D, 60, 0, "R9 full bank"); ack(); clr();
      clr_ovr = 1'b1; @(negedge clk); clr_ovr = 1'b0;

      // R11 ack and clear in the same cycle
      restart();
      fill(1, 70); arm(); fill(2, 71); arm();
      get_pkt(1, 70, 0, "R11 bank0"); ack();
      chk("R11 pending", int'(txcmpl), 1);
      get_pkt(2, 71, 1, "R11 bank1");
      host_ack = 1'b1; clr_cmpl = 1'b1; @(negedge clk);
      host_ack = 1'b0; clr_cmpl = 1'b0;
      chk("R11 ack during clear stays", int'(txcmpl), 1);
      clr();
      chk("R11 second clear", int'(txcmpl), 0);

      // R10 disable clears arming and toggle
      restart();
      fill(2, 95); arm();
      chk("R10 armed before disable", int'(wr_bank), 1);
      ep_en = 1'b0; @(negedge clk);
      chk("R10 wr_bank reset", int'(wr_bank), 0);
      ep_en = 1'b1; @(negedge clk);
      in_tok = 1'b1; @(negedge clk); in_tok = 1'b0;
      chk("R10 bank disarmed", int'(tx_nak), 1);
      @(negedge clk);
      fill(1, 96); arm();
      get_pkt(1, 96, 0, "R10 DATA0 after enable"); ack(); clr();

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule